// File: doc/BRIEF.md
# Dual-Channel Timer Clock-Enable Generator

This block produces one single-cycle count-enable pulse per timer channel. Two channels are served, and each has its own 3-bit source selector. A selector can choose nothing, the undivided system clock, one of four divided rates from a single shared 10-bit prescaler counter, or an edge of that channel's external pin of a chosen polarity. The timers themselves live outside the block. A timer advances by one on each cycle in which its enable pulse is high.

A small register port lets software program the two selectors and a general control register. That register holds a hold-mode flag (bit 7) and a prescaler-clear flag (bit 0). A four-state control machine owns both flags. The states are CS_RUN (neither flag set), CS_PULSE (clear set, hold clear), CS_ARMED (hold set, clear not set) and CS_HOLD (both set). A control-register write moves the machine to the state named by the written bit 7 and bit 0. With no write, CS_PULSE moves to CS_RUN on the next clock, and every other state stays where it is.

While the machine is in CS_PULSE or CS_HOLD, the prescaler is held at zero and all clock-derived pulses are blocked on both channels. Software sets hold mode together with the clear flag, configures its timers, and then writes zero. Both channels then restart from the same prescaler phase.

Top module: `tcg_top`

## Requirements
- R1: Selector code 0 never produces a pulse on that channel.
- R2: Selector code 1 produces a pulse in every cycle in which the prescaler is not being cleared.
- R3: Selector codes 2, 3, 4 and 5 give one pulse every 8, 64, 256 and 1024 cycles. After a prescaler clear ends, the first pulse falls on the Nth running cycle, counting the first cycle after the clear as 1.
- R4: Code 7 pulses on rising edges and code 6 on falling edges of the channel's external pin. There is one pulse per qualifying edge, and it is high in the cycle that follows the second clock edge after the pin changes. An edge of the other polarity gives no pulse.
- R5: Both channels take their divided rates from the same counter, so after one clear their pulses line up. Two prescaled channels pulse together on every common multiple of their periods.
- R6: Writing 0x01 to the control register (address 2) makes it read 0x01 for one cycle. It then reads 0x00 without any further write.
- R7: Writing 0x81 keeps the control register at 0x81. No pulse is produced for codes 1 to 5 on either channel, for as long as the value is held.
- R8: Writing 0x00 after a hold restarts both channels on the same cycle. In the first cycle after that write a code-1 channel pulses, and a code-2 channel first pulses 7 cycles later.
- R9: Address 0 holds the channel 0 selector and address 1 the channel 1 selector, each in bits 2:0, with the other bits reading zero. Address 2 reads the hold flag in bit 7 and the clear flag in bit 0, with bits 6:1 reading zero. Address 3 reads zero, and every register resets to zero.
- R10: External-pin pulses are still produced while the prescaler is held in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational from rd_addr |
| ext_pin | input | 2 | External count inputs, one per channel |
| tick | output | 2 | Count-enable pulse, one per channel |

## Verification
A register write takes effect at the clock edge that captures it. The readback and the pulse outputs show the new state in the half cycle after that edge. A clear pulse ends one edge later, so the first running cycle is the second cycle after the write. In the stimulus, inputs change on falling edges and outputs are sampled on falling edges. Cycles are counted from the write, so each divided pulse is expected at an exact index k, where k is a multiple of N. An external pulse is expected at the second falling-edge sample after the pin change, and the cycles on either side of it are checked to be low.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

    localparam int SEL_W    = 3;
    localparam int NUM_TAPS = 1 << SEL_W;

    typedef enum logic [1:0] {
        CS_RUN   = 2'd0,
        CS_PULSE = 2'd1,
        CS_ARMED = 2'd2,
        CS_HOLD  = 2'd3
    } ctl_state_t;

    localparam logic [SEL_W-1:0] SEL_OFF      = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DIV1     = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DIV1024  = 3'd5;
    localparam logic [SEL_W-1:0] SEL_EXT_FALL = 3'd6;
    localparam logic [SEL_W-1:0] SEL_EXT_RISE = 3'd7;

    // number of low prescaler bits that must all be one for a divided tap
    function automatic int tap_bits(input int code);
        case (code)
            2:       return 3;
            3:       return 6;
            4:       return 8;
            5:       return 10;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/tcg_ctrl.sv
module tcg_ctrl
    import tcg_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic [NUM_CH*SEL_W-1:0] sel_flat,
    output logic                    presc_rst
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);
    localparam int                HOLD_BIT  = DATA_W - 1;
    localparam int                CLR_BIT   = 0;

    ctl_state_t state_q, state_d;
    logic       ctrl_wr;
    logic       hold_flag;
    logic [SEL_W-1:0] sel_q [NUM_CH];
    logic       unused_bits;

    assign ctrl_wr     = wr_en && (wr_addr == CTRL_ADDR);
    assign unused_bits = ^wr_data[HOLD_BIT-1:SEL_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            unique case ({wr_data[HOLD_BIT], wr_data[CLR_BIT]})
                2'b00: state_d = CS_RUN;
                2'b01: state_d = CS_PULSE;
                2'b10: state_d = CS_ARMED;
                2'b11: state_d = CS_HOLD;
            endcase
        end else begin
            unique case (state_q)
                CS_PULSE: state_d = CS_RUN;
                CS_RUN, CS_ARMED, CS_HOLD: state_d = state_q;
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        unique case (state_q)
            CS_RUN:   begin hold_flag = 1'b0; presc_rst = 1'b0; end
            CS_PULSE: begin hold_flag = 1'b0; presc_rst = 1'b1; end
            CS_ARMED: begin hold_flag = 1'b1; presc_rst = 1'b0; end
            CS_HOLD:  begin hold_flag = 1'b1; presc_rst = 1'b1; end
        endcase
    end

    // per-channel selector registers
    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sel_q[c] <= SEL_OFF;
            else if (wr_en && wr_addr == ADDR_W'(c))
                sel_q[c] <= wr_data[SEL_W-1:0];
        end
        assign sel_flat[c*SEL_W +: SEL_W] = sel_q[c];
    end

    // readback
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == ADDR_W'(c)) rd_data[SEL_W-1:0] = sel_q[c];
        end
        if (rd_addr == CTRL_ADDR) begin
            rd_data[HOLD_BIT] = hold_flag;
            rd_data[CLR_BIT]  = presc_rst;
        end
    end

    // R6: a lone clear pulse ends on its own
    a_r6_pulse_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_PULSE && !ctrl_wr) |=> (state_q == CS_RUN && !presc_rst));

    // R7: hold mode keeps the clear asserted
    a_r7_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_HOLD && !ctrl_wr) |=> presc_rst);

    // R8: writing zero releases the clear on the next cycle
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_data[HOLD_BIT] && !wr_data[CLR_BIT]) |=> !presc_rst);

endmodule

// File: rtl/tcg_prescaler.sv
module tcg_prescaler
    import tcg_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    output logic [CNT_W-1:0]    cnt,
    output logic [NUM_TAPS-1:0] taps
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        if (t >= int'(SEL_DIV1) && t <= int'(SEL_DIV1024)) begin : g_live
            localparam int B = tap_bits(t);
            if (B == 0) begin : g_undiv
                assign taps[t] = ~clr;
            end else begin : g_div
                assign taps[t] = ~clr & (&cnt[B-1:0]);
            end
        end else begin : g_dead
            assign taps[t] = 1'b0;
        end
    end

endmodule

// File: rtl/tcg_edge.sv
module tcg_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise =  sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] &  prev_q;

    // R4: one pulse per qualifying edge
    a_r4_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    a_r4_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/tcg_tickmux.sv
module tcg_tickmux
    import tcg_pkg::*;
(
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic                rise,
    input  logic                fall,
    output logic                tick
);

    always_comb begin
        unique case (sel)
            SEL_OFF:      tick = 1'b0;
            SEL_EXT_FALL: tick = fall;
            SEL_EXT_RISE: tick = rise;
            default:      tick = taps[sel];
        endcase
    end

endmodule

// File: rtl/tcg_top.sv
module tcg_top
    import tcg_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_CH-1:0] ext_pin,
    output logic [NUM_CH-1:0] tick
);

    logic [NUM_CH*SEL_W-1:0] sel_flat;
    logic                    presc_rst;
    logic [CNT_W-1:0]        presc_cnt;
    logic [NUM_TAPS-1:0]     taps;

    tcg_ctrl #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .sel_flat  (sel_flat),
        .presc_rst (presc_rst)
    );

    tcg_prescaler #(
        .CNT_W (CNT_W)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (presc_rst),
        .cnt   (presc_cnt),
        .taps  (taps)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic             rise, fall;
        logic [SEL_W-1:0] sel;

        assign sel = sel_flat[c*SEL_W +: SEL_W];

        tcg_edge #(
            .STAGES (SYNC_STAGES)
        ) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (ext_pin[c]),
            .rise  (rise),
            .fall  (fall)
        );

        tcg_tickmux u_mux (
            .sel  (sel),
            .taps (taps),
            .rise (rise),
            .fall (fall),
            .tick (tick[c])
        );

        // R1: an unclocked channel stays silent
        a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == SEL_OFF) |-> !tick[c]);

        // R7: clock-derived sources are blocked while the prescaler is cleared
        a_r7_halted_taps: assert property (@(posedge clk) disable iff (!rst_n)
            (presc_rst && sel >= SEL_DIV1 && sel <= SEL_DIV1024) |-> !tick[c]);
    end

    // R3: the shared counter wraps to zero after its top value
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_cnt == '1 && !presc_rst) |=> (presc_cnt == '0));

    // R5: a clear leaves the shared counter at zero for the next cycle
    a_r5_shared_zero: assert property (@(posedge clk) disable iff (!rst_n)
        presc_rst |=> (presc_cnt == '0));

endmodule

// File: tb/sim_tcg_top.sv
`timescale 1ns/1ps
module sim_tcg_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] ext_pin = '0;
    logic [1:0] tick;

    int  nchk = 0;
    int  nbad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    tcg_top u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ext_pin (ext_pin),
        .tick    (tick)
    );

    // {channel 0 code, channel 1 code} in octal
    localparam logic [5:0] VEC [0:4] = '{6'o12, 6'o34, 6'o50, 6'o25, 6'o01};
    localparam int WINDOW = 1100;

    function automatic int period(input logic [2:0] code);
        case (code)
            3'd1:    return 1;
            3'd2:    return 8;
            3'd3:    return 64;
            3'd4:    return 256;
            3'd5:    return 1024;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] code);
        if (code == 3'd0) return "R1";
        if (code == 3'd1) return "R2";
        return "R3";
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R9, R1)
        chk(tick == 2'b00, "R1", int'(tick), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 8'h00, "R9", int'(v), 0);
        end

        // vector table: divided and undivided rates (R1 R2 R3 R5)
        for (int i = 0; i < 5; i++) begin
            logic [2:0] c0, c1;
            int p0, p1, m0, m1, both, exp_both;
            c0 = VEC[i][5:3];
            c1 = VEC[i][2:0];
            p0 = period(c0);
            p1 = period(c1);
            m0 = 0; m1 = 0; both = 0; exp_both = 0;
            wr(2'd0, {5'd0, c0});
            wr(2'd1, {5'd0, c1});
            wr(2'd2, 8'h01);
            if (tick != 2'b00) begin m0++; m1++; end
            for (int k = 1; k <= WINDOW; k++) begin
                bit e0, e1;
                @(negedge clk);
                e0 = (p0 != 0) && (k % p0 == 0);
                e1 = (p1 != 0) && (k % p1 == 0);
                if (tick[0] != e0) m0++;
                if (tick[1] != e1) m1++;
                if (tick[0] && tick[1]) both++;
                if (e0 && e1) exp_both++;
            end
            chk(m0 == 0, req_of(c0), m0, 0);
            chk(m1 == 0, req_of(c1), m1, 0);
            if (p0 > 1 && p1 > 1)
                chk(both == exp_both, "R5", both, exp_both);
        end

        // single clear pulse self-clears (R6)
        wr(2'd2, 8'h01);
        rd(2'd2, v);
        chk(v == 8'h01, "R6", int'(v), 1);
        @(negedge clk);
        rd(2'd2, v);
        chk(v == 8'h00, "R6", int'(v), 0);

        // register map (R9)
        wr(2'd0, 8'hFF);
        rd(2'd0, v);
        chk(v == 8'h07, "R9", int'(v), 7);
        wr(2'd2, 8'h7E);
        rd(2'd2, v);
        chk(v == 8'h00, "R9", int'(v), 0);
        rd(2'd3, v);
        chk(v == 8'h00, "R9", int'(v), 0);

        // hold and simultaneous release (R7 R8)
        begin
            int cnt_hold, f0, f1;
            cnt_hold = 0; f0 = 0; f1 = 0;
            wr(2'd0, 8'd2);
            wr(2'd1, 8'd1);
            wr(2'd2, 8'h81);
            rd(2'd2, v);
            chk(v == 8'h81, "R7", int'(v), 129);
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (tick != 2'b00) cnt_hold++;
            end
            chk(cnt_hold == 0, "R7", cnt_hold, 0);
            rd(2'd2, v);
            chk(v == 8'h81, "R7", int'(v), 129);
            wr(2'd2, 8'h00);
            for (int k = 1; k <= 16; k++) begin
                if (k > 1) @(negedge clk);
                if (tick[0] && f0 == 0) f0 = k;
                if (tick[1] && f1 == 0) f1 = k;
            end
            chk(f1 == 1, "R8", f1, 1);
            chk(f0 == 8, "R8", f0, 8);
        end

        // external edges (R4)
        begin
            int t1;
            wr(2'd0, 8'd7);
            wr(2'd1, 8'd6);
            repeat (4) @(negedge clk);
            ext_pin[0] = 1'b1;
            @(negedge clk);
            chk(tick[0] == 1'b0, "R4", int'(tick[0]), 0);
            @(negedge clk);
            chk(tick[0] == 1'b1, "R4", int'(tick[0]), 1);
            @(negedge clk);
            chk(tick[0] == 1'b0, "R4", int'(tick[0]), 0);
            t1 = 0;
            ext_pin[1] = 1'b1;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (tick[1]) t1++;
            end
            chk(t1 == 0, "R4", t1, 0);
            ext_pin[1] = 1'b0;
            @(negedge clk);
            chk(tick[1] == 1'b0, "R4", int'(tick[1]), 0);
            @(negedge clk);
            chk(tick[1] == 1'b1, "R4", int'(tick[1]), 1);
        end

        // external edges while the prescaler is held (R10)
        begin
            int n;
            n = 0;
            wr(2'd2, 8'h81);
            for (int e = 0; e < 4; e++) begin
                ext_pin[0] = 1'b0;
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    if (tick[0]) n++;
                end
                ext_pin[0] = 1'b1;
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    if (tick[0]) n++;
                end
            end
            chk(n == 4, "R10", n, 4);
            wr(2'd2, 8'h00);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule